// File: doc/BRIEF.md
# Selectable Even-Ratio Clock Divider

This block takes one source clock and produces a slower clock from it. A 3-bit ratio code selects one of eight even division ratios, from 2 up to 16 in steps of two. The output has a 50 % duty cycle at every ratio. Each output half-period lasts a whole number of source cycles, and a down-counter measures it.

A divider-reset input lets the surrounding logic put the output back into a known phase. The block samples this input on the falling edge of the source clock. While the sampled reset is high, the output is held low and the counter is preloaded. The output then rises a fixed number of source cycles after the release. The ratio code is registered and only changes the period at an output toggle, so the half-period in progress always finishes at its old length.

With ratio code 0 the output inverts on every source rising edge. Registers that capture on both edges of this output therefore capture once per source cycle, while the output itself runs at half the source rate.

Top module: `clkdiv_even`

## Requirements
- R1: Ratio code s (0 to 7) on `ratio_sel` gives an output period of 2*(s+1) source clock cycles: 2, 4, 6, ... 16.
- R2: The output is high for exactly s+1 source cycles and low for exactly s+1 source cycles (50 % duty cycle), and it changes only on a source rising edge.
- R3: `div_rst` is sampled only on the falling edge of `src_clk`. A pulse that lies entirely between two falling edges has no effect on the output.
- R4: In every source cycle after a falling edge that sampled `div_rst` high, `div_clk` is low, including when the reset arrives while the output is high.
- R5: After the reset is sampled low, count the source rising edges starting with the first edge that sees the low sample as edge 1. The output rises at edge s+1 and then continues with the R1 period.
- R6: A change of `ratio_sel` is taken at the next output toggle. The half-period in progress keeps its old length, and every half-period after that toggle uses the new length.
- R7: While the divider is held in reset, the ratio code present on the last reset cycle sets the ratio that applies after release.
- R8: With ratio code 0, `div_clk` inverts on every source rising edge, so each of its levels lasts exactly one source period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_clk | input | 1 | Source clock; its rising edge drives the counter and the output, its falling edge samples the divider reset |
| div_rst | input | 1 | Divider reset, active high, sampled on the falling edge of `src_clk` |
| ratio_sel | input | 3 | Ratio code s; the divisor is 2*(s+1) |
| div_clk | output | 1 | Divided clock output |

## Verification
The bench measures the high and low run lengths for all eight ratio codes, counting from a reset release. A design with an off-by-one reload would produce runs of s or s+2 cycles, and one that divides by s+1 instead of 2*(s+1) would fail the period checks. A reset pulse placed so that it straddles a rising edge but no falling edge must leave the waveform unchanged. A design that samples on the rising edge would restart its phase there. A ratio change is applied in the middle of a high phase: a design that reloads at once would shorten or stretch that phase. A reset that lands while the output is high must pull the output low within one cycle, and a design that waits for the next toggle would leave it high.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  // Half-period length, in source cycles, for ratio code s.
  function automatic int unsigned half_len(input int unsigned s);
    return s + 1;
  endfunction

  // Full division ratio for ratio code s.
  function automatic int unsigned divisor(input int unsigned s);
    return 2 * half_len(s);
  endfunction
endpackage

// File: rtl/clkdiv_rst_sample.sv
module clkdiv_rst_sample (
  input  logic clk,
  input  logic rst_in,
  output logic rst_q
);
  // The divider reset is captured on the falling edge of the source clock.
  always_ff @(negedge clk) begin
    rst_q <= rst_in;
  end
endmodule

// File: rtl/clkdiv_count.sv
module clkdiv_count
  import clkdiv_pkg::*;
#(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] sel_in,
  output logic             tick
);
  localparam int CNT_W = SEL_W;

  logic [CNT_W-1:0] cnt;
  logic [SEL_W-1:0] act_sel;
  logic [CNT_W-1:0] reload_val;

  // Reload value for the half-period that starts at this edge.
  assign reload_val = CNT_W'(half_len(int'(sel_in)) - 1);
  // Toggle boundary: the current half-period ends.
  assign tick       = !rst && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      act_sel <= sel_in;
      cnt     <= reload_val;
    end else if (tick) begin
      act_sel <= sel_in;
      cnt     <= reload_val;
    end else begin
      cnt     <= cnt - 1'b1;
    end
  end

  // R1: the count never exceeds the half-period of the latched ratio
  assert_cnt_bound_R1: assert property (@(posedge clk) disable iff (rst)
    int'(cnt) <= int'(half_len(int'(act_sel))) - 1);

  // R6: the latched ratio only moves at a toggle boundary
  assert_sel_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(act_sel));

  // R7: while reset is held, the counter is preloaded from the live ratio code
  assert_reset_load_R7: assert property (@(posedge clk)
    rst |=> (int'(cnt) == int'(half_len(int'($past(sel_in)))) - 1));
endmodule

// File: rtl/clkdiv_phase.sv
module clkdiv_phase (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= 1'b0;
    else if (tick) q <= ~q;
  end

  // R4: a sampled reset forces the output low on the next rising edge
  assert_reset_low_R4: assert property (@(posedge clk) rst |=> !q);
endmodule

// File: rtl/clkdiv_even.sv
module clkdiv_even #(
  parameter int SEL_W = 3
) (
  input  logic             src_clk,
  input  logic             div_rst,
  input  logic [SEL_W-1:0] ratio_sel,
  output logic             div_clk
);
  logic rst_q;
  logic tick;

  clkdiv_rst_sample u_rst (
    .clk    (src_clk),
    .rst_in (div_rst),
    .rst_q  (rst_q)
  );

  clkdiv_count #(.SEL_W(SEL_W)) u_cnt (
    .clk    (src_clk),
    .rst    (rst_q),
    .sel_in (ratio_sel),
    .tick   (tick)
  );

  clkdiv_phase u_ph (
    .clk  (src_clk),
    .rst  (rst_q),
    .tick (tick),
    .q    (div_clk)
  );

  // R2: every counter boundary inverts the output
  assert_toggle_R2: assert property (@(posedge src_clk) disable iff (rst_q)
    tick |=> (div_clk != $past(div_clk)));

  // R2: between boundaries the output holds its level
  assert_hold_R2: assert property (@(posedge src_clk) disable iff (rst_q)
    !tick |=> $stable(div_clk));
endmodule

// File: tb/clkdiv_even_tb.sv
`timescale 1ns/100ps
module clkdiv_even_tb;
  logic       clk = 1'b1;
  logic       div_rst = 1'b1;
  logic [2:0] ratio_sel = 3'd0;
  logic       div_clk;
  int         total = 0;
  int         bad = 0;
  int         cyc = 0;
  bit         done = 0;

  clkdiv_even u_dut (
    .src_clk   (clk),
    .div_rst   (div_rst),
    .ratio_sel (ratio_sel),
    .div_clk   (div_clk)
  );

  always #2 clk = ~clk;

  // Bench's own statement of the waveform after release: rises at edge h,
  // then alternates every h edges.
  function automatic logic exp_val(input int k, input int h);
    if (k < h) return 1'b0;
    return (((k - h) / h) % 2) == 0;
  endfunction

  task automatic chk(input logic act, input logic exp, input string req, input int k);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s edge %0d: div_clk=%b expected %b", req, k, act, exp);
    end
  endtask

  task automatic samp(output logic v);
    @(posedge clk);
    #1 v = div_clk;
  endtask

  // Hold reset for n cycles with code s, release right after a rising edge.
  task automatic do_reset(input int s, input int n);
    @(posedge clk);
    #1 div_rst = 1'b1;
    ratio_sel = 3'(s);
    repeat (n) @(posedge clk);
    #1 div_rst = 1'b0;
  endtask

  task automatic t_reset_state();
    logic v;
    samp(v);
    chk(v, 1'b0, "R4", 0);
  endtask

  task automatic t_ratio(input int s);
    logic v;
    int h = s + 1;
    do_reset(s, 3);
    for (int k = 1; k <= 5 * h; k++) begin
      samp(v);
      chk(v, exp_val(k, h), (s == 0) ? "R8" : ((k <= h) ? "R5" : "R1/R2"), k);
    end
  endtask

  task automatic t_glitch();
    logic v;
    int h = 3;
    do_reset(2, 2);
    for (int k = 1; k <= 6 * h; k++) begin
      if (k == 5 || k == 9) begin
        // pulse covers one rising edge but no falling edge
        #1.5 div_rst = 1'b1;
        @(posedge clk);
        #1 div_rst = 1'b0;
        v = div_clk;
      end else begin
        samp(v);
      end
      chk(v, exp_val(k, h), "R3", k);
    end
  endtask

  task automatic t_reset_mid();
    logic v;
    int h = 4;
    do_reset(3, 2);
    for (int k = 1; k <= h + 1; k++) samp(v);
    chk(v, 1'b1, "R4", h + 1);
    @(posedge clk);
    #1 div_rst = 1'b1;
    for (int k = 0; k < 4; k++) begin
      samp(v);
      chk(v, 1'b0, "R4", k);
    end
    #0 div_rst = 1'b0;
    for (int k = 1; k <= 3 * h; k++) begin
      samp(v);
      chk(v, exp_val(k, h), "R5", k);
    end
  endtask

  task automatic t_sel_change();
    logic v;
    logic exp_seq [1:13] = '{0,1,1,0,0,0,0,1,1,1,1,0,0};
    do_reset(1, 2);
    for (int k = 1; k <= 13; k++) begin
      samp(v);
      chk(v, exp_seq[k], "R6", k);
      if (k == 2) ratio_sel = 3'd3;
    end
  endtask

  task automatic t_sel_in_reset();
    logic v;
    int h = 8;
    @(posedge clk);
    #1 div_rst = 1'b1;
    ratio_sel = 3'd2;
    repeat (2) @(posedge clk);
    #1 ratio_sel = 3'd7;
    @(posedge clk);
    #1 div_rst = 1'b0;
    for (int k = 1; k <= 3 * h; k++) begin
      samp(v);
      chk(v, exp_val(k, h), "R7", k);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset_state();
    for (int s = 0; s < 8; s++) t_ratio(s);
    t_glitch();
    t_reset_mid();
    t_sel_change();
    t_sel_in_reset();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog: cycles=%0d expected completion", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule